// File: doc/BRIEF.md
# Trap Entry State Updater

This block computes the architectural register updates a register-windowed processor core performs when it enters a trap. A trap request carries a 9-bit trap type and a snapshot of the current state: trap level, global level, condition codes, address-space identifier, processor state word, hyperprivileged state word, current window pointer, spare-window count, PC and next PC. On one clock edge the unit raises the trap level, builds a packed trap-state word, and stores it with the return addresses, the hyperprivileged state and the trap type into a small per-level trap stack. The stack is indexed by the new trap level. In the same edge it registers the new global level, the new processor state word and the new window pointer.

Requests use a valid/ready handshake. `req_ready` is high whenever the unit is idle, and a request is taken on an edge where both `req_valid` and `req_ready` are high. In the cycle after acceptance, `done` pulses and `req_ready` is low, so the caller must hold or resubmit the request through that cycle; no request is lost or merged. Window spill and fill traps also produce a redirect to a fixed handler base address. A separate combinational read port shows any stack level.

Top module: `trap_entry_unit`

## Requirements
- R1: `req_ready` is 1 when `done` is 0 and 0 when `done` is 1. A request accepted on edge k makes `done` 1 for exactly the cycle after edge k.
- R2: Without error, `out_tl` equals the incoming trap level plus 1. The saved record is written to stack level `in_tl+1` and can be read on the read port with `rd_lvl` set to that level. Stack levels run from 1 to MAX_TL.
- R3: The packed trap-state word places the global level at bits 42:40, condition codes at 39:32, address-space identifier at 31:24, processor state word at 20:8 and the window pointer, zero-extended, at 4:0. All other bits are 0.
- R4: The saved PC equals `in_pc`, the saved next PC equals `in_npc`, the saved hyperprivileged state equals `in_hpstate`, and the saved trap type equals `req_tt`.
- R5: The new processor state word sets bits 4 and 2, clears bits 3 and 1, copies bit 8 into bit 9, and keeps every other bit.
- R6: The new global level is `in_gl+1`, saturated at MAX_GL.
- R7: Trap type 0x024 advances the window pointer by 1, modulo the window count.
- R8: Trap types 0x080 to 0x0BF advance the window pointer by `in_cansave+2`, modulo the window count.
- R9: Trap types 0x0C0 to 0x0FF move the window pointer back by 1, modulo the window count.
- R10: Any other trap type leaves the window pointer unchanged.
- R11: Spill types (R8) set `redirect` and give targets SPILL_VEC, +4 and +8. Fill types (R9) do the same with FILL_VEC. For all other types `redirect` and the three targets are 0.
- R12: When `in_tl` is MAX_TL or higher, `err` pulses with `done`. The stack is left unwritten, `out_tl`, `out_gl`, `out_pstate` and `out_cwp` equal the inputs, and `redirect` is 0.
- R13: After reset, `done`, `err`, `redirect` and all `out_*` values are 0, and every stack level reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request present |
| req_ready | output | 1 | Unit idle, can take a request |
| req_tt | input | 9 | Trap type |
| in_tl | input | LW | Current trap level |
| in_gl | input | 3 | Current global level |
| in_ccr | input | 8 | Condition codes |
| in_asi | input | 8 | Address-space identifier |
| in_pstate | input | 13 | Processor state word |
| in_hpstate | input | HPS_W | Hyperprivileged state word |
| in_cwp | input | CW | Current window pointer |
| in_cansave | input | CW | Spare window count |
| in_pc | input | ADDR_W | Current PC |
| in_npc | input | ADDR_W | Current next PC |
| done | output | 1 | Update committed (one-cycle pulse) |
| err | output | 1 | Trap level overflow, no update |
| out_tl | output | LW | New trap level |
| out_gl | output | 3 | New global level |
| out_pstate | output | 13 | New processor state word |
| out_cwp | output | CW | New window pointer |
| out_tstate | output | 43 | Packed trap-state word |
| out_tpc | output | ADDR_W | Saved PC |
| out_tnpc | output | ADDR_W | Saved next PC |
| out_htstate | output | HPS_W | Saved hyperprivileged state |
| out_tt | output | 9 | Saved trap type |
| redirect | output | 1 | Spill/fill handler redirect |
| redir_pc | output | ADDR_W | Handler PC |
| redir_npc | output | ADDR_W | Handler next PC |
| redir_nnpc | output | ADDR_W | Handler following PC |
| rd_lvl | input | LW | Stack level to read |
| rd_tstate | output | 43 | Stack trap-state word |
| rd_tpc | output | ADDR_W | Stack saved PC |
| rd_tnpc | output | ADDR_W | Stack saved next PC |
| rd_htstate | output | HPS_W | Stack saved hyperprivileged state |
| rd_tt | output | 9 | Stack saved trap type |

## Verification
Every registered result (`done`, `err`, all `out_*` and the redirect targets) is due in the cycle right after the accepting edge. The stack contents appear on the combinational read port from that same cycle on. The bench drives inputs on falling edges. The monitor pops the expected record and compares it on the first falling edge after acceptance, which is the only cycle in which `done` is high. Ready is checked low in that same cycle. In the following cycle the bench checks that `done` has dropped, then reads the affected stack level and compares it with a shadow stack kept by the bench.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int TT_W   = 9;
  localparam int CCR_W  = 8;
  localparam int ASI_W  = 8;
  localparam int PST_W  = 13;
  localparam int GL_W   = 3;
  localparam int TST_W  = 43;

  typedef enum logic [1:0] {
    TK_PLAIN = 2'd0,
    TK_CLEAN = 2'd1,
    TK_SPILL = 2'd2,
    TK_FILL  = 2'd3
  } trap_kind_e;

  function automatic trap_kind_e classify(input logic [TT_W-1:0] tt);
    if (tt == 9'h024)                       return TK_CLEAN;
    else if (tt >= 9'h080 && tt <= 9'h0BF)  return TK_SPILL;
    else if (tt >= 9'h0C0 && tt <= 9'h0FF)  return TK_FILL;
    else                                    return TK_PLAIN;
  endfunction

  function automatic logic [TST_W-1:0] pack_tstate(
      input logic [GL_W-1:0]  gl,
      input logic [CCR_W-1:0] ccr,
      input logic [ASI_W-1:0] asi,
      input logic [PST_W-1:0] pst,
      input logic [4:0]       cwp5);
    logic [TST_W-1:0] w;
    w = '0;
    w[42:40] = gl;
    w[39:32] = ccr;
    w[31:24] = asi;
    w[20:8]  = pst;
    w[4:0]   = cwp5;
    return w;
  endfunction
endpackage

// File: rtl/trap_pstate_xform.sv
module trap_pstate_xform
  import trap_pkg::*;
(
  input  logic [PST_W-1:0] pst_in,
  output logic [PST_W-1:0] pst_out
);
  always_comb begin
    pst_out    = pst_in;
    pst_out[4] = 1'b1;
    pst_out[3] = 1'b0;
    pst_out[2] = 1'b1;
    pst_out[1] = 1'b0;
    pst_out[9] = pst_in[8];
  end
endmodule

// File: rtl/trap_cwp_adjust.sv
module trap_cwp_adjust
  import trap_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  trap_kind_e      kind,
  input  logic [CW-1:0]   cwp_in,
  input  logic [CW-1:0]   cansave,
  output logic [CW-1:0]   cwp_out
);
  logic [CW+1:0] spill_sum;
  logic [CW+1:0] fill_sum;
  logic [CW+1:0] clean_sum;

  always_comb begin
    spill_sum = {2'b00, cwp_in} + {2'b00, cansave} + (CW+2)'(2);
    fill_sum  = {2'b00, cwp_in} + (CW+2)'(NWIN - 1);
    clean_sum = {2'b00, cwp_in} + (CW+2)'(1);
    unique case (kind)
      TK_CLEAN: cwp_out = CW'(32'(clean_sum) % NWIN);
      TK_SPILL: cwp_out = CW'(32'(spill_sum) % NWIN);
      TK_FILL:  cwp_out = CW'(32'(fill_sum)  % NWIN);
      default:  cwp_out = cwp_in;
    endcase
  end

  always_comb begin
    a_r10_plain_keeps: assert (kind != TK_PLAIN || cwp_out == cwp_in);
  end
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
  parameter int DEPTH = 6,
  parameter int ENT_W = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_lvl,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [LW-1:0]    rd_lvl,
  output logic [ENT_W-1:0] rd_data
);
  logic [ENT_W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ent[i] <= '0;
      else if (wr_en && wr_lvl == LW'(i + 1))       ent[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_lvl == LW'(i + 1)) rd_data = ent[i];
  end

  a_r12_no_write_level0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_lvl != '0 && 32'(wr_lvl) <= DEPTH));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int ADDR_W = 64,
  parameter int HPS_W  = 12,
  parameter logic [ADDR_W-1:0] SPILL_VEC = ADDR_W'(64'h4000),
  parameter logic [ADDR_W-1:0] FILL_VEC  = ADDR_W'(64'h6000),
  localparam int LW = $clog2(MAX_TL + 1),
  localparam int CW = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [8:0]        req_tt,
  input  logic [LW-1:0]     in_tl,
  input  logic [2:0]        in_gl,
  input  logic [7:0]        in_ccr,
  input  logic [7:0]        in_asi,
  input  logic [12:0]       in_pstate,
  input  logic [HPS_W-1:0]  in_hpstate,
  input  logic [CW-1:0]     in_cwp,
  input  logic [CW-1:0]     in_cansave,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_npc,
  output logic              done,
  output logic              err,
  output logic [LW-1:0]     out_tl,
  output logic [2:0]        out_gl,
  output logic [12:0]       out_pstate,
  output logic [CW-1:0]     out_cwp,
  output logic [42:0]       out_tstate,
  output logic [ADDR_W-1:0] out_tpc,
  output logic [ADDR_W-1:0] out_tnpc,
  output logic [HPS_W-1:0]  out_htstate,
  output logic [8:0]        out_tt,
  output logic              redirect,
  output logic [ADDR_W-1:0] redir_pc,
  output logic [ADDR_W-1:0] redir_npc,
  output logic [ADDR_W-1:0] redir_nnpc,
  input  logic [LW-1:0]     rd_lvl,
  output logic [42:0]       rd_tstate,
  output logic [ADDR_W-1:0] rd_tpc,
  output logic [ADDR_W-1:0] rd_tnpc,
  output logic [HPS_W-1:0]  rd_htstate,
  output logic [8:0]        rd_tt
);
  localparam int ENT_W = TST_W + 2 * ADDR_W + HPS_W + TT_W;

  logic             accept;
  logic             tl_full;
  trap_kind_e       kind;
  logic [LW-1:0]    tl_next;
  logic [2:0]       gl_next;
  logic [12:0]      pst_next;
  logic [CW-1:0]    cwp_next;
  logic [42:0]      tst_word;
  logic             is_wf;
  logic [ADDR_W-1:0] vec_base;
  logic [ENT_W-1:0] wr_ent;
  logic [ENT_W-1:0] rd_ent;

  assign req_ready = !done;
  assign accept    = req_valid && req_ready;
  assign tl_full   = 32'(in_tl) >= MAX_TL;
  assign kind      = classify(req_tt);
  assign tl_next   = in_tl + LW'(1);
  assign gl_next   = (32'(in_gl) >= MAX_GL) ? 3'(MAX_GL) : in_gl + 3'd1;
  assign tst_word  = pack_tstate(in_gl, in_ccr, in_asi, in_pstate, 5'(in_cwp));
  assign is_wf     = (kind == TK_SPILL) || (kind == TK_FILL);
  assign vec_base  = (kind == TK_SPILL) ? SPILL_VEC : FILL_VEC;
  assign wr_ent    = {tst_word, in_pc, in_npc, in_hpstate, req_tt};

  trap_pstate_xform u_pst (
    .pst_in  (in_pstate),
    .pst_out (pst_next)
  );

  trap_cwp_adjust #(.NWIN(NWIN)) u_cwp (
    .kind    (kind),
    .cwp_in  (in_cwp),
    .cansave (in_cansave),
    .cwp_out (cwp_next)
  );

  trap_stack #(.DEPTH(MAX_TL), .ENT_W(ENT_W)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && !tl_full),
    .wr_lvl  (tl_next),
    .wr_data (wr_ent),
    .rd_lvl  (rd_lvl),
    .rd_data (rd_ent)
  );

  assign {rd_tstate, rd_tpc, rd_tnpc, rd_htstate, rd_tt} = rd_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      err         <= 1'b0;
      out_tl      <= '0;
      out_gl      <= '0;
      out_pstate  <= '0;
      out_cwp     <= '0;
      out_tstate  <= '0;
      out_tpc     <= '0;
      out_tnpc    <= '0;
      out_htstate <= '0;
      out_tt      <= '0;
      redirect    <= 1'b0;
      redir_pc    <= '0;
      redir_npc   <= '0;
      redir_nnpc  <= '0;
    end else if (accept) begin
      done        <= 1'b1;
      err         <= tl_full;
      out_tstate  <= tst_word;
      out_tpc     <= in_pc;
      out_tnpc    <= in_npc;
      out_htstate <= in_hpstate;
      out_tt      <= req_tt;
      if (tl_full) begin
        out_tl     <= in_tl;
        out_gl     <= in_gl;
        out_pstate <= in_pstate;
        out_cwp    <= in_cwp;
        redirect   <= 1'b0;
        redir_pc   <= '0;
        redir_npc  <= '0;
        redir_nnpc <= '0;
      end else begin
        out_tl     <= tl_next;
        out_gl     <= gl_next;
        out_pstate <= pst_next;
        out_cwp    <= cwp_next;
        redirect   <= is_wf;
        redir_pc   <= is_wf ? vec_base : '0;
        redir_npc  <= is_wf ? vec_base + ADDR_W'(4) : '0;
        redir_nnpc <= is_wf ? vec_base + ADDR_W'(8) : '0;
      end
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
    end
  end

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  a_r1_accept_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> done);
  a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !redirect));
  a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && 32'(in_tl) < MAX_TL) |=> out_tl == $past(in_tl) + LW'(1));
  a_r5_priv_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (out_pstate[2] && !out_pstate[1] && out_pstate[4] && !out_pstate[3]));
  a_r6_gl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(out_gl) <= MAX_GL || err));
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  localparam int NWIN = 8, MAX_TL = 6, MAX_GL = 3, ADDR_W = 64, HPS_W = 12;
  localparam int LW = 3, CW = 3;
  localparam logic [63:0] SV = 64'h0000_0000_0001_4000;
  localparam logic [63:0] FV = 64'h0000_0000_0001_6000;

  typedef struct packed {
    logic        err;
    logic [2:0]  tl;
    logic [2:0]  gl;
    logic [12:0] pst;
    logic [2:0]  cwp;
    logic [42:0] tst;
    logic [63:0] tpc;
    logic [63:0] tnpc;
    logic [11:0] hps;
    logic [8:0]  tt;
    logic        rdr;
    logic [63:0] rpc;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [8:0] req_tt = 0;
  logic [2:0] in_tl = 0, in_gl = 0, in_cwp = 0, in_cansave = 0;
  logic [7:0] in_ccr = 0, in_asi = 0;
  logic [12:0] in_pstate = 0;
  logic [11:0] in_hpstate = 0;
  logic [63:0] in_pc = 0, in_npc = 0;
  logic done, err, redirect;
  logic [2:0] out_tl, out_gl, out_cwp;
  logic [12:0] out_pstate;
  logic [42:0] out_tstate, rd_tstate;
  logic [63:0] out_tpc, out_tnpc, redir_pc, redir_npc, redir_nnpc, rd_tpc, rd_tnpc;
  logic [11:0] out_htstate, rd_htstate;
  logic [8:0] out_tt, rd_tt;
  logic [2:0] rd_lvl = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  exp_t q[$];
  logic [42:0] sh_tst [1:MAX_TL];
  logic [63:0] sh_tpc [1:MAX_TL];
  logic [8:0]  sh_tt  [1:MAX_TL];

  always #10 clk = ~clk;

  trap_entry_unit #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .ADDR_W(ADDR_W),
                    .HPS_W(HPS_W), .SPILL_VEC(SV), .FILL_VEC(FV)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_tt, .in_tl, .in_gl, .in_ccr, .in_asi,
    .in_pstate, .in_hpstate, .in_cwp, .in_cansave, .in_pc, .in_npc, .done, .err,
    .out_tl, .out_gl, .out_pstate, .out_cwp, .out_tstate, .out_tpc, .out_tnpc,
    .out_htstate, .out_tt, .redirect, .redir_pc, .redir_npc, .redir_nnpc, .rd_lvl,
    .rd_tstate, .rd_tpc, .rd_tnpc, .rd_htstate, .rd_tt);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] gl,
      input logic [7:0] ccr, input logic [7:0] asi, input logic [12:0] p, input logic [11:0] h,
      input logic [2:0] cw, input logic [2:0] cs, input logic [63:0] pc, input logic [63:0] npc);
    exp_t e;
    int w;
    e = '0;
    e.tst[42:40] = gl; e.tst[39:32] = ccr; e.tst[31:24] = asi;
    e.tst[20:8] = p;   e.tst[4:0] = {2'b00, cw};
    e.tpc = pc; e.tnpc = npc; e.hps = h; e.tt = tt;
    if (tl >= 3'(MAX_TL)) begin
      e.err = 1; e.tl = tl; e.gl = gl; e.pst = p; e.cwp = cw;
    end else begin
      e.tl = tl + 3'd1;
      e.gl = (gl >= 3'(MAX_GL)) ? 3'(MAX_GL) : gl + 3'd1;
      e.pst = p; e.pst[4] = 1; e.pst[3] = 0; e.pst[2] = 1; e.pst[1] = 0; e.pst[9] = p[8];
      w = int'(cw);
      if (tt == 9'h024) w = (w + 1) % NWIN;
      else if (tt >= 9'h080 && tt <= 9'h0BF) begin
        w = (w + int'(cs) + 2) % NWIN; e.rdr = 1; e.rpc = SV;
      end else if (tt >= 9'h0C0 && tt <= 9'h0FF) begin
        w = (w + NWIN - 1) % NWIN; e.rdr = 1; e.rpc = FV;
      end
      e.cwp = 3'(w);
    end
    return e;
  endfunction

  // monitor: compares the popped record in the done cycle
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R1 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        chk(err == e.err, "R12 err", 64'(err), 64'(e.err));
        chk(out_tl == e.tl, "R2 tl", 64'(out_tl), 64'(e.tl));
        chk(out_gl == e.gl, "R6 gl", 64'(out_gl), 64'(e.gl));
        chk(out_pstate == e.pst, "R5 pstate", 64'(out_pstate), 64'(e.pst));
        chk(out_cwp == e.cwp, "R7-R10 cwp R7 R8 R9 R10", 64'(out_cwp), 64'(e.cwp));
        chk(redirect == e.rdr, "R11 redirect", 64'(redirect), 64'(e.rdr));
        chk(redir_pc == e.rpc && redir_npc == (e.rdr ? e.rpc + 4 : 64'd0)
            && redir_nnpc == (e.rdr ? e.rpc + 8 : 64'd0), "R11 targets", redir_pc, e.rpc);
        if (!e.err) begin
          chk(out_tstate == e.tst, "R3 tstate", 64'(out_tstate), 64'(e.tst));
          chk(out_tpc == e.tpc && out_tnpc == e.tnpc, "R4 pcs", out_tpc, e.tpc);
          chk(out_htstate == e.hps && out_tt == e.tt, "R4 hps/tt", 64'(out_tt), 64'(e.tt));
        end
      end
    end
  end

  task automatic trap(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] gl,
      input logic [12:0] p, input logic [2:0] cw, input logic [2:0] cs);
    exp_t e;
    logic [2:0] lvl;
    @(negedge clk);
    req_tt = tt; in_tl = tl; in_gl = gl; in_pstate = p; in_cwp = cw; in_cansave = cs;
    in_ccr = 8'h5A ^ 8'(tt); in_asi = 8'h80 + 8'(tl); in_hpstate = 12'hA50 ^ 12'(tt);
    in_pc = 64'h1000_0000 + 64'(tt) * 4; in_npc = in_pc + 4;
    req_valid = 1;
    chk(req_ready == 1, "R1 ready idle", 64'(req_ready), 1);
    e = model(tt, tl, gl, in_ccr, in_asi, p, in_hpstate, cw, cs, in_pc, in_npc);
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
    chk(done == 1 && req_ready == 0, "R1 done/busy", 64'({done, req_ready}), 64'b10);
    if (!e.err) begin
      sh_tst[e.tl] = e.tst; sh_tpc[e.tl] = e.tpc; sh_tt[e.tl] = e.tt;
    end
    lvl = e.err ? 3'(MAX_TL) : e.tl;
    @(negedge clk);
    chk(done == 0, "R1 pulse width", 64'(done), 0);
    rd_lvl = lvl;
    #1;
    chk(rd_tstate == sh_tst[lvl] && rd_tpc == sh_tpc[lvl] && rd_tt == sh_tt[lvl],
        e.err ? "R12 stack untouched" : "R2 stack entry", 64'(rd_tt), 64'(sh_tt[lvl]));
  endtask

  initial begin
    for (int i = 1; i <= MAX_TL; i++) begin sh_tst[i] = '0; sh_tpc[i] = '0; sh_tt[i] = '0; end
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(done == 0 && err == 0 && redirect == 0 && out_tl == 0 && out_cwp == 0 && out_tstate == 0,
        "R13 reset outputs", 64'(out_tl), 0);
    rd_lvl = 3'd1; #1;
    chk(rd_tstate == 0 && rd_tpc == 0, "R13 stack zero", 64'(rd_tstate), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", 64'(req_ready), 1);
    // plain and boundary types, R10
    trap(9'h010, 3'd0, 3'd0, 13'h0000, 3'd5, 3'd2);
    trap(9'h023, 3'd1, 3'd1, 13'h1FFF, 3'd3, 3'd1);
    trap(9'h025, 3'd2, 3'd2, 13'h0100, 3'd7, 3'd0);
    trap(9'h07F, 3'd3, 3'd3, 13'h0200, 3'd0, 3'd4);
    trap(9'h100, 3'd4, 3'd0, 13'h0A0A, 3'd6, 3'd7);
    // clean window R7 incl wrap at last window
    trap(9'h024, 3'd0, 3'd1, 13'h0155, 3'd3, 3'd0);
    trap(9'h024, 3'd5, 3'd2, 13'h1EAA, 3'd7, 3'd0);
    // spill R8 incl wrap
    trap(9'h080, 3'd1, 3'd0, 13'h0000, 3'd2, 3'd1);
    trap(9'h0BF, 3'd2, 3'd3, 13'h0300, 3'd6, 3'd7);
    trap(9'h0A4, 3'd3, 3'd2, 13'h0010, 3'd7, 3'd0);
    // fill R9 incl wrap at window 0
    trap(9'h0C0, 3'd0, 3'd0, 13'h1000, 3'd0, 3'd3);
    trap(9'h0FF, 3'd4, 3'd1, 13'h00FF, 3'd5, 3'd3);
    // R6 saturation at MAX_GL, R2 top level
    trap(9'h011, 3'd5, 3'd3, 13'h0004, 3'd1, 3'd0);
    // R12 overflow at MAX_TL with a spill type
    trap(9'h090, 3'(MAX_TL), 3'd1, 13'h0102, 3'd4, 3'd2);
    trap(9'h0C8, 3'(MAX_TL), 3'd2, 13'h0000, 3'd0, 3'd0);
    // R2 all levels retain their records
    for (int l = 1; l <= MAX_TL; l++) begin
      rd_lvl = 3'(l); #1;
      chk(rd_tstate == sh_tst[l] && rd_tpc == sh_tpc[l] && rd_tt == sh_tt[l],
          "R2 level readback", 64'(rd_tt), 64'(sh_tt[l]));
    end
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R1 all results seen", 64'(q.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule